// File: doc/BRIEF.md
# Electronic Shutter Pulse Scheduler

This block decides when, inside a frame, the image sensor's substrate is pulsed to empty every photodiode. The pulse starts the exposure, and the exposure ends at the next transfer into the vertical registers at frame start. Exposure is therefore set by the line whose horizontal retrace carries the pulse. A later line gives a shorter exposure. The frame rate stays fixed.

The line sequencer supplies the current line index and a one-cycle strobe at the start of each horizontal retrace. It also marks the frame start, which coincides with the photodiode transfer. The exposure line and the enable are sampled only at frame start. On the chosen line the block raises a hold request, and the sequencer stretches that retrace while the request is high. Inside the hold, the block waits a front guard, drives the shutter enable to the external high-voltage driver for a fixed width, and then keeps horizontal clocking halted for a rear guard. A line that would leave less than the minimum exposure is clamped, and the clamp is flagged for the whole frame.

Top module: `shutter_sched`

## Requirements
- R1: While reset is asserted and after it is released, `shut_en`, `retrace_hold` and `exp_clamped` are 0 until a frame start arms the block.
- R2: The pulse is issued only in response to a `retrace_start` strobe seen while `line_idx` equals the target line latched for the frame. `shut_en` then stays high for exactly PULSE_CYC cycles.
- R3: `retrace_hold` rises in the cycle after the triggering strobe. `shut_en` stays low for the first GUARD_PRE cycles of the hold.
- R4: `retrace_hold` remains high for exactly GUARD_POST cycles after `shut_en` falls, then drops. `shut_en` is never high while `retrace_hold` is low.
- R5: At most one pulse is issued between two frame starts.
- R6: `exp_line` and `shutter_on` are sampled only in a cycle with `frame_start` high. Changes at any other time do not affect the current frame.
- R7: The latest permitted line is MAX_LINE = LINES - MIN_LINES. If `exp_line` exceeds it while `shutter_on` is 1 at frame start, the target becomes MAX_LINE and `exp_clamped` reads 1 from the next cycle until the next frame start. Otherwise `exp_clamped` reads 0.
- R8: With `shutter_on` at 0 at frame start, no pulse and no hold are produced in that frame.
- R9: A `retrace_start` strobe on a non-target line, or one received while a hold sequence is running, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle strobe at the transfer that opens a frame |
| line_idx | input | LW | Current line index from the sequencer |
| retrace_start | input | 1 | One-cycle strobe when horizontal clocking stops for a retrace |
| exp_line | input | LW | Requested line for the shutter pulse |
| shutter_on | input | 1 | 1 enables the electronic shutter for the next frame |
| shut_en | output | 1 | Shutter enable to the high-voltage driver |
| retrace_hold | output | 1 | Request to keep horizontal clocking stopped |
| exp_clamped | output | 1 | The current frame's line was clamped |

## Verification
The assertions check on every cycle that the shutter never goes high outside a hold, that each pulse has the exact width and follows a full front guard, that a hold only begins after a retrace strobe, that no frame receives a second pulse, and that the clamp flag tracks the values sampled at frame start. Other properties need the bench's whole-frame scenarios. These are that the pulse lands on the intended line, that mid-frame changes to the setting are deferred, that a disabled frame stays silent, and that stray strobes during a hold are ignored. The bench checks them against a behavioural model compared on every clock and against per-frame pulse counts.

// File: rtl/shutter_sched.sv
module shutter_sched #(
  parameter int LINES      = 16,
  parameter int MIN_LINES  = 3,
  parameter int GUARD_PRE  = 3,
  parameter int PULSE_CYC  = 8,
  parameter int GUARD_POST = 4,
  localparam int LW        = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic [LW-1:0] line_idx,
  input  logic          retrace_start,
  input  logic [LW-1:0] exp_line,
  input  logic          shutter_on,
  output logic          shut_en,
  output logic          retrace_hold,
  output logic          exp_clamped
);
  localparam int MAX_LINE = LINES - MIN_LINES;
  localparam logic [LW-1:0] MAX_L = LW'(MAX_LINE);
  localparam int L1 = (GUARD_PRE > PULSE_CYC) ? GUARD_PRE : PULSE_CYC;
  localparam int LONGEST = (L1 > GUARD_POST) ? L1 : GUARD_POST;
  localparam int CW = $clog2(LONGEST + 1);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_FIRE, S_POST} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [LW-1:0] tgt;
  logic          armed;
  logic          over, fire;

  assign over = exp_line > MAX_L;
  assign fire = (st == S_IDLE) && armed && retrace_start && (line_idx == tgt);
  assign shut_en = (st == S_FIRE);
  assign retrace_hold = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      tgt         <= '0;
      armed       <= 1'b0;
      exp_clamped <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (fire) begin
          st    <= S_PRE;
          cnt   <= CW'(GUARD_PRE - 1);
          armed <= 1'b0;
        end
        S_PRE: if (cnt == '0) begin
          st  <= S_FIRE;
          cnt <= CW'(PULSE_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_FIRE: if (cnt == '0) begin
          st  <= S_POST;
          cnt <= CW'(GUARD_POST - 1);
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) st <= S_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
      if (frame_start) begin
        armed       <= shutter_on;
        tgt         <= over ? MAX_L : exp_line;
        exp_clamped <= shutter_on && over;
      end
    end
  end
endmodule

// File: rtl/shutter_sched_chk.sv
module shutter_sched_chk #(
  parameter int LW         = 4,
  parameter int MAX_LINE   = 13,
  parameter int GUARD_PRE  = 3,
  parameter int PULSE_CYC  = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_start,
  input logic          retrace_start,
  input logic [LW-1:0] exp_line,
  input logic          shutter_on,
  input logic          shut_en,
  input logic          retrace_hold,
  input logic          exp_clamped
);
  logic [15:0] pre_run, width;
  logic [1:0]  rises;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_run <= '0;
      width   <= '0;
      rises   <= '0;
    end else begin
      pre_run <= (retrace_hold && !shut_en) ? ((pre_run == 16'hFFFF) ? pre_run : pre_run + 1'b1) : '0;
      width   <= shut_en ? ((width == 16'hFFFF) ? width : width + 1'b1) : '0;
      if (frame_start) rises <= '0;
      else if (shut_en && width == '0 && rises != 2'd3) rises <= rises + 1'b1;
    end
  end

  a_r4_shut_inside_hold: assert property (@(posedge clk) disable iff (!rst_n)
    shut_en |-> retrace_hold);
  a_r3_front_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_en && !$past(shut_en)) |-> (pre_run >= 16'(GUARD_PRE)));
  a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shut_en) |-> (width == 16'(PULSE_CYC)));
  a_r9_hold_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retrace_hold) |-> $past(retrace_start));
  a_r5_one_per_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_en && width == '0 && !frame_start) |-> (rises == 2'd0));
  a_r7_clamp_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_start) |-> (exp_clamped == ($past(shutter_on) && ($past(exp_line) > LW'(MAX_LINE)))));
  a_r6_flag_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(frame_start) && $past(rst_n)) |-> $stable(exp_clamped));
endmodule

bind shutter_sched shutter_sched_chk #(
  .LW(LW), .MAX_LINE(MAX_LINE), .GUARD_PRE(GUARD_PRE), .PULSE_CYC(PULSE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .retrace_start(retrace_start),
  .exp_line(exp_line), .shutter_on(shutter_on), .shut_en(shut_en),
  .retrace_hold(retrace_hold), .exp_clamped(exp_clamped)
);

// File: tb/shutter_sched_bench.sv
module shutter_sched_bench;
  localparam int LINES = 16, MIN_LINES = 3, PRE = 3, PUL = 8, POST = 4;
  localparam int LW = $clog2(LINES);
  localparam int MAXL = LINES - MIN_LINES;
  localparam int TOT = PRE + PUL + POST;

  logic clk = 0, rst_n = 0, frame_start = 0, retrace_start = 0, shutter_on = 0;
  logic [LW-1:0] line_idx = '0, exp_line = '0;
  logic shut_en, retrace_hold, exp_clamped;

  int checks = 0, failures = 0, cycles = 0;
  int m_t = -1, m_armed = 0, m_tgt = 0, m_clamp = 0;
  int rises = 0, rise_line = -1, holds = 0;
  logic prev_shut = 0, prev_hold = 0;

  always #4 clk = ~clk;

  shutter_sched #(.LINES(LINES), .MIN_LINES(MIN_LINES), .GUARD_PRE(PRE),
                  .PULSE_CYC(PUL), .GUARD_POST(POST)) u_shutter_sched (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_idx(line_idx),
    .retrace_start(retrace_start), .exp_line(exp_line), .shutter_on(shutter_on),
    .shut_en(shut_en), .retrace_hold(retrace_hold), .exp_clamped(exp_clamped));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_t = -1; m_armed = 0; m_tgt = 0; m_clamp = 0;
    end else begin
      if (m_t >= 0) begin
        m_t++;
        if (m_t == TOT) m_t = -1;
      end else if (retrace_start && m_armed != 0 && int'(line_idx) == m_tgt) begin
        m_t = 0; m_armed = 0;
      end
      if (frame_start) begin
        m_armed = shutter_on;
        m_tgt   = (int'(exp_line) > MAXL) ? MAXL : int'(exp_line);
        m_clamp = (shutter_on && int'(exp_line) > MAXL) ? 1 : 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R4 hold", retrace_hold, (m_t >= 0) ? 1 : 0);
      check("R2/R3 shut", shut_en, (m_t >= PRE && m_t < PRE + PUL) ? 1 : 0);
      check("R7 clamp", exp_clamped, m_clamp);
      if (shut_en && !prev_shut) begin rises++; rise_line = int'(line_idx); end
      if (retrace_hold && !prev_hold) holds++;
    end
    prev_shut = shut_en;
    prev_hold = retrace_hold;
  end

  task automatic frame(input bit on, input int ex, input bit late_on, input int late_ex, input bit stray);
    @(negedge clk);
    frame_start = 1; shutter_on = on; exp_line = LW'(ex);
    @(negedge clk);
    frame_start = 0; shutter_on = late_on; exp_line = LW'(late_ex);
    rises = 0; rise_line = -1; holds = 0;
    for (int l = 0; l < LINES; l++) begin
      line_idx = LW'(l);
      repeat (3) @(negedge clk);
      retrace_start = 1;
      @(negedge clk);
      retrace_start = 0;
      if (stray) begin
        @(negedge clk);
        retrace_start = 1;
        @(negedge clk);
        retrace_start = 0;
      end
      while (retrace_hold) @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic judge(input bit on, input int ex);
    int want_line;
    want_line = (ex > MAXL) ? MAXL : ex;
    if (on) begin
      check("R5 pulses per frame", rises, 1);
      check("R2/R7 pulse line", rise_line, want_line);
    end else begin
      check("R8 no pulse when off", rises, 0);
      check("R8 no hold when off", holds, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 shut in reset", shut_en, 0);
    check("R1 hold in reset", retrace_hold, 0);
    check("R1 clamp in reset", exp_clamped, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check("R1 idle after reset", {shut_en, retrace_hold, exp_clamped}, 0);

    frame(1, 5, 1, 5, 0);   judge(1, 5);
    frame(1, 0, 1, 0, 0);   judge(1, 0);
    frame(1, 13, 1, 13, 0); judge(1, 13);
    frame(1, 14, 1, 14, 0); judge(1, 14);
    check("R7 clamp flag held", exp_clamped, 1);
    frame(1, 15, 1, 15, 1); judge(1, 15);
    frame(0, 7, 0, 7, 0);   judge(0, 7);
    check("R7 flag clear when off", exp_clamped, 0);
    frame(1, 9, 0, 2, 1);   judge(1, 9);
    frame(0, 4, 1, 4, 1);   judge(0, 4);
    frame(1, 11, 1, 3, 0);  judge(1, 11);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 200000);
    failures++;
    $display("FAIL watchdog actual=%0d expected<=200000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule